// File: doc/BRIEF.md
# Ten-bit-address I2C write receiver

This block is the receive side of an I2C target that answers only to 10-bit addresses. It watches the open-drain SCL and SDA lines through synchronizing, de-glitching filters and finds START and STOP conditions. It matches the two address bytes that follow a START against a single 8-bit compare register and a 5-bit don't-care mask. It acknowledges matching bytes by pulling SDA low during the ninth clock, and it copies each accepted byte into a receive buffer.

Between the two address bytes, and again after the second one, the block stretches the clock. It keeps SCL low and raises an update request until host logic rewrites the compare register. The first time the host loads the low address byte, and the second time the high-byte pattern. Each accepted byte sets a buffer-full flag and an interrupt flag. A data byte that arrives while the buffer is still unread is refused with a NACK and raises an overflow flag.

The host side is a small register port. Select 0 is the compare address (read/write). Select 1 is the mask (read/write). Select 2 is the receive buffer, and reading it with the pop strobe clears buffer-full. Select 3 is status and flag clears.

Top module: `i2c10_slave_rx`

## Requirements
- R1: After reset, scl_oe, sda_oe and irq are 0, the status register reads 0 and the compare register reads 0.
- R2: The first byte after START is acknowledged (SDA pulled low during the ninth clock) only when bits [7:3] are 11110, bits [2:1] equal compare-register bits [2:1] and bit 0 (R/W) is 0. The mask has no effect on this byte.
- R3: The second address byte is acknowledged only when every bit equals the compare register, except for bits made don't-care by the mask. Mask bit 0 covers bits 1 and 0, and mask bit k (k = 1 to 4) covers bit k+1. Bits 7 and 6 are always compared.
- R4: After each acknowledged address byte, status bit 1 (update request) is set and scl_oe is held at 1 until the host writes select 0. That write clears the request and releases SCL.
- R5: Every acknowledged byte, address or data, is copied into the receive buffer. It also sets status bit 0 (buffer full) and status bit 3 (interrupt), and irq follows status bit 3. Writing a 1 to status bit 3 clears the interrupt.
- R6: Reading select 2 with the pop strobe returns the buffer and clears buffer full.
- R7: A data byte that completes while buffer full is set gets a NACK and sets status bit 2 (overflow). The buffer keeps its old value. Overflow clears only when a 1 is written to status bit 2.
- R8: No clock stretching follows a data byte: scl_oe stays 0.
- R9: A STOP returns the receiver to idle. Bytes clocked afterwards without a new START are not acknowledged and change no flag.
- R10: An address byte that does not match is refused with a NACK and sets no flag. Later bytes in the same transfer are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| reg_sel | input | 2 | Register select: 0 compare, 1 mask, 2 buffer, 3 status |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Buffer pop strobe (effective with select 2) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the selected register |
| irq | output | 1 | Interrupt flag level |

## Verification
The assertions assume that SCL and SDA hold each level for longer than the synchronizer and filter depth. They also assume that SDA changes only while SCL is low, except at START and STOP. Under those assumptions every filtered edge stands for one real bus event, and no acknowledge starts while SCL is high. The bench master holds every phase for several system clocks. It changes SDA only with SCL low, and it honours a stretched clock by waiting for SCL to read high. Host register strobes are driven on the falling clock edge, so no write lands on an undefined cycle relative to the bus logic.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;
  localparam int BYTE_W = 8;
  localparam int MASK_W = 5;
  localparam int CNT_W  = 4;
  localparam logic [4:0] HI_PREFIX = 5'b11110;

  localparam logic [1:0] SEL_CMP  = 2'd0;
  localparam logic [1:0] SEL_MASK = 2'd1;
  localparam logic [1:0] SEL_BUF  = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_DATA
  } rx_state_e;
endpackage

// File: rtl/i2c10_line_filter.sv
module i2c10_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_STAGES-1:0] hist_q;
  logic                   lvl_q, lvl_d, prev_q;

  always_comb begin
    lvl_d = lvl_q;
    if (&hist_q)       lvl_d = 1'b1;
    else if (~|hist_q) lvl_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '1;
      lvl_q  <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      hist_q <= {hist_q[FILT_STAGES-2:0], sync_q[SYNC_STAGES-1]};
      lvl_q  <= lvl_d;
      prev_q <= lvl_q;
    end
  end

  assign level_o = lvl_q;
  assign rise_o  = lvl_q & ~prev_q;
  assign fall_o  = ~lvl_q & prev_q;
endmodule

// File: rtl/i2c10_addr_cmp.sv
module i2c10_addr_cmp
  import i2c10_pkg::*;
#(
  parameter int MW = MASK_W
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [BYTE_W-1:0] cmp_i,
  input  logic [MW-1:0]     mask_i,
  output logic              hi_hit_o,
  output logic              lo_hit_o
);
  logic [BYTE_W-1:0] dont_care;

  // Mask bit 0 spans the two lowest address bits, the others one bit each.
  for (genvar b = 0; b < BYTE_W; b++) begin : g_dc
    if (b < 2) begin : g_pair
      assign dont_care[b] = mask_i[0];
    end else if (b <= MW) begin : g_single
      assign dont_care[b] = mask_i[b-1];
    end else begin : g_fixed
      assign dont_care[b] = 1'b0;
    end
  end

  assign lo_hit_o = (((byte_i ^ cmp_i) & ~dont_care) == '0);
  assign hi_hit_o = (byte_i[7:3] == HI_PREFIX) && (byte_i[2:1] == cmp_i[2:1]) && !byte_i[0];
endmodule

// File: rtl/i2c10_slave_rx.sv
module i2c10_slave_rx
  import i2c10_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic [1:0] reg_sel,
  input  logic       reg_we,
  input  logic       reg_re,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

  logic scl_f, scl_rise, scl_fall;
  logic sda_f, sda_rise, sda_fall;
  logic hi_hit, lo_hit;
  logic start_det, stop_det, cmp_we;

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  bitcnt_q, bitcnt_d;
  logic [BYTE_W-1:0] shreg_q, shreg_d;
  logic [BYTE_W-1:0] rxbuf_q, rxbuf_d;
  logic [BYTE_W-1:0] cmp_q, cmp_d;
  logic [MASK_W-1:0] mask_q, mask_d;
  logic ack_q, ack_d, sda_oe_q, sda_oe_d;
  logic bf_q, bf_d, ua_q, ua_d, ovf_q, ovf_d, irq_q, irq_d;
  logic ack_now;

  i2c10_line_filter #(.SYNC_STAGES(2), .FILT_STAGES(2)) i_scl_filt (
    .clk(clk), .rst_n(rst_n), .line_i(scl_i),
    .level_o(scl_f), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  i2c10_line_filter #(.SYNC_STAGES(2), .FILT_STAGES(2)) i_sda_filt (
    .clk(clk), .rst_n(rst_n), .line_i(sda_i),
    .level_o(sda_f), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  i2c10_addr_cmp #(.MW(MASK_W)) i_cmp (
    .byte_i(shreg_q), .cmp_i(cmp_q), .mask_i(mask_q),
    .hi_hit_o(hi_hit), .lo_hit_o(lo_hit)
  );

  assign start_det = sda_fall & scl_f;
  assign stop_det  = sda_rise & scl_f;
  assign cmp_we    = reg_we && (reg_sel == SEL_CMP);

  always_comb begin
    state_d  = state_q;
    bitcnt_d = bitcnt_q;
    shreg_d  = shreg_q;
    rxbuf_d  = rxbuf_q;
    cmp_d    = cmp_q;
    mask_d   = mask_q;
    ack_d    = ack_q;
    sda_oe_d = sda_oe_q;
    bf_d     = bf_q;
    ua_d     = ua_q;
    ovf_d    = ovf_q;
    irq_d    = irq_q;
    ack_now  = 1'b0;

    // Host side first, so that a bus event in the same cycle wins.
    if (reg_we) begin
      case (reg_sel)
        SEL_CMP: begin
          cmp_d = reg_wdata;
          ua_d  = 1'b0;
        end
        SEL_MASK: mask_d = reg_wdata[MASK_W-1:0];
        SEL_STAT: begin
          if (reg_wdata[2]) ovf_d = 1'b0;
          if (reg_wdata[3]) irq_d = 1'b0;
        end
        default: ;
      endcase
    end
    if (reg_re && (reg_sel == SEL_BUF)) bf_d = 1'b0;

    if (start_det) begin
      state_d  = ST_ADDR_HI;
      bitcnt_d = '0;
      sda_oe_d = 1'b0;
      ack_d    = 1'b0;
    end else if (stop_det) begin
      state_d  = ST_IDLE;
      bitcnt_d = '0;
      sda_oe_d = 1'b0;
      ack_d    = 1'b0;
    end else if (state_q != ST_IDLE) begin
      if (scl_rise) begin
        if (bitcnt_q < LAST_BIT) begin
          shreg_d  = {shreg_q[BYTE_W-2:0], sda_f};
          bitcnt_d = bitcnt_q + 1'b1;
        end else if (bitcnt_q == LAST_BIT) begin
          bitcnt_d = ACK_BIT;
        end
      end else if (scl_fall) begin
        if (bitcnt_q == LAST_BIT) begin
          case (state_q)
            ST_ADDR_HI: ack_now = hi_hit;
            ST_ADDR_LO: ack_now = lo_hit;
            ST_DATA: begin
              ack_now = !bf_q;
              if (bf_q) ovf_d = 1'b1;
            end
            default: ack_now = 1'b0;
          endcase
          ack_d    = ack_now;
          sda_oe_d = ack_now;
        end else if (bitcnt_q == ACK_BIT) begin
          sda_oe_d = 1'b0;
          bitcnt_d = '0;
          ack_d    = 1'b0;
          if (ack_q) begin
            rxbuf_d = shreg_q;
            bf_d    = 1'b1;
            irq_d   = 1'b1;
            if (state_q == ST_ADDR_HI) begin
              ua_d    = 1'b1;
              state_d = ST_ADDR_LO;
            end else if (state_q == ST_ADDR_LO) begin
              ua_d    = 1'b1;
              state_d = ST_DATA;
            end
          end else if (state_q != ST_DATA) begin
            state_d = ST_IDLE;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      rxbuf_q  <= '0;
      cmp_q    <= '0;
      mask_q   <= '0;
      ack_q    <= 1'b0;
      sda_oe_q <= 1'b0;
      bf_q     <= 1'b0;
      ua_q     <= 1'b0;
      ovf_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      bitcnt_q <= bitcnt_d;
      shreg_q  <= shreg_d;
      rxbuf_q  <= rxbuf_d;
      cmp_q    <= cmp_d;
      mask_q   <= mask_d;
      ack_q    <= ack_d;
      sda_oe_q <= sda_oe_d;
      bf_q     <= bf_d;
      ua_q     <= ua_d;
      ovf_q    <= ovf_d;
      irq_q    <= irq_d;
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_CMP:  reg_rdata = cmp_q;
      SEL_MASK: reg_rdata = BYTE_W'(mask_q);
      SEL_BUF:  reg_rdata = rxbuf_q;
      default:  reg_rdata = {4'b0000, irq_q, ovf_q, ua_q, bf_q};
    endcase
  end

  assign scl_oe = ua_q;
  assign sda_oe = sda_oe_q;
  assign irq    = irq_q;

  // R4: the update request persists until the host rewrites the compare address
  assert_ua_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ua_q && !cmp_we) |=> ua_q);
  // R4: a compare-address write outside a bus clock edge releases SCL
  assert_ua_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_we && !scl_fall) |=> !scl_oe);
  // R2: the acknowledge is only ever started while the filtered clock is low
  assert_ack_clk_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_q) |-> !scl_f);
  // R7: an overflowing byte is never acknowledged
  assert_no_overflow_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> !sda_oe_q);
  // R7: while data is pending, the buffer keeps its contents
  assert_buf_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA && bf_q) |=> $stable(rxbuf_q));
  // R5: an interrupt always comes with a full buffer
  assert_irq_with_bf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> bf_q);
endmodule

// File: tb/test_i2c10_slave_rx.sv
module test_i2c10_slave_rx;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam logic [7:0] HI_CMP = 8'hF4;
  localparam logic [7:0] LO_CMP = 8'hA5;

  logic clk = 1'b0;
  logic rst_n;
  logic m_scl_low, m_sda_low;
  logic scl, sda, scl_oe, sda_oe, irq;
  logic [1:0] reg_sel;
  logic reg_we, reg_re;
  logic [7:0] reg_wdata, reg_rdata;
  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl = ~(m_scl_low | scl_oe);
  assign sda = ~(m_sda_low | sda_oe);

  i2c10_slave_rx i_i2c10_slave_rx (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_re(reg_re), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic reg_write(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] s, input bit pop, output logic [7:0] d);
    @(negedge clk);
    reg_sel = s;
    #1 d = reg_rdata;
    reg_re = pop;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic bus_start();
    m_sda_low = 1'b1; wclk(2*Q);
    m_scl_low = 1'b1; wclk(Q);
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; wclk(Q);
    m_scl_low = 1'b0; wait (scl === 1'b1); wclk(2*Q);
    m_sda_low = 1'b0; wclk(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = ~b[i]; wclk(Q);
      m_scl_low = 1'b0; wait (scl === 1'b1); wclk(2*Q);
      m_scl_low = 1'b1; wclk(Q);
    end
    m_sda_low = 1'b0; wclk(Q);
    m_scl_low = 1'b0; wait (scl === 1'b1); wclk(Q);
    ack = (sda == 1'b0);
    wclk(Q);
    m_scl_low = 1'b1; wclk(Q);
  endtask

  // After an accepted address byte: check flags and hold, rewrite compare, empty buffer.
  task automatic service_addr(input logic [7:0] sent, input logic [7:0] next_cmp, input string tag);
    logic [7:0] v;
    reg_read(2'd3, 1'b0, v);
    check(v[3:0] == 4'hB, {tag, " R4 R5 status"}, v, 4'hB);
    check(scl_oe == 1'b1, {tag, " R4 scl held"}, scl_oe, 1);
    check(irq == 1'b1, {tag, " R5 irq"}, irq, 1);
    wclk(3*Q);
    check(scl_oe == 1'b1, {tag, " R4 still held"}, scl_oe, 1);
    reg_write(2'd0, next_cmp);
    wclk(2);
    check(scl_oe == 1'b0, {tag, " R4 released"}, scl_oe, 0);
    reg_read(2'd2, 1'b1, v);
    check(v == sent, {tag, " R5 buffer"}, v, sent);
    reg_read(2'd3, 1'b0, v);
    check(v[1:0] == 2'b00, {tag, " R6 bf cleared"}, v[1:0], 0);
    reg_write(2'd3, 8'h08);
  endtask

  task automatic finish_report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    wclk(200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_report();
  end

  initial begin
    logic [7:0] v, b, m;
    bit ack, exp_ack;
    m_scl_low = 0; m_sda_low = 0;
    reg_sel = 0; reg_we = 0; reg_re = 0; reg_wdata = 0;
    rst_n = 0;
    wclk(5);
    @(negedge clk) rst_n = 1;
    wclk(4);

    // R1 reset state
    check(scl_oe == 0 && sda_oe == 0, "R1 pins released", {scl_oe, sda_oe}, 0);
    check(irq == 0, "R1 irq", irq, 0);
    reg_read(2'd3, 1'b0, v); check(v == 8'h00, "R1 status", v, 0);
    reg_read(2'd0, 1'b0, v); check(v == 8'h00, "R1 compare", v, 0);

    // R2 sweep of the first address byte, mask all ones (must have no effect)
    reg_write(2'd1, 8'h1F);
    reg_write(2'd0, HI_CMP);
    for (int j = 0; j < 40; j++) begin
      b = (j < 32) ? {j[4:0], 3'b100} : {5'b11110, j[2:0]};
      exp_ack = (b[7:3] == 5'b11110) && (b[2:1] == HI_CMP[2:1]) && !b[0];
      bus_start();
      send_byte(b, ack);
      check(ack == exp_ack, $sformatf("R2 hi byte %02h", b), ack, exp_ack);
      if (ack) service_addr(b, HI_CMP, "R2");
      else begin
        reg_read(2'd3, 1'b0, v);
        check(v == 8'h00, "R10 no flags on miss", v, 0);
      end
      bus_stop();
    end

    // R3 sweep of mask patterns with single-bit flips of the low byte
    for (int k = 0; k < 8; k++) begin
      m = (k == 0) ? 8'h00 : (k < 6) ? 8'(1 << (k - 1)) : (k == 6) ? 8'h09 : 8'h1F;
      reg_write(2'd1, m);
      for (int i = 0; i < 9; i++) begin
        reg_write(2'd0, HI_CMP);
        b = (i == 8) ? LO_CMP : (LO_CMP ^ 8'(1 << i));
        if (i == 8) exp_ack = 1;
        else if (i < 2) exp_ack = m[0];
        else if (i < 6) exp_ack = m[i-1];
        else exp_ack = 0;
        bus_start();
        send_byte(HI_CMP, ack);
        check(ack, "R2 hi accepted", ack, 1);
        service_addr(HI_CMP, LO_CMP, "R4 hi");
        send_byte(b, ack);
        check(ack == exp_ack, $sformatf("R3 mask %02h low %02h", m, b), ack, exp_ack);
        if (ack) service_addr(b, HI_CMP, "R3");
        else begin
          reg_read(2'd3, 1'b0, v);
          check(v == 8'h00, "R10 no flags on low miss", v, 0);
        end
        bus_stop();
      end
    end

    // Data phase: R5 R6 R7 R8
    reg_write(2'd1, 8'h00);
    reg_write(2'd0, HI_CMP);
    bus_start();
    send_byte(HI_CMP, ack); check(ack, "R2 data hi", ack, 1);
    service_addr(HI_CMP, LO_CMP, "R4 data hi");
    send_byte(LO_CMP, ack); check(ack, "R3 data lo", ack, 1);
    service_addr(LO_CMP, HI_CMP, "R4 data lo");
    send_byte(8'h3C, ack); check(ack, "R5 data ack", ack, 1);
    check(scl_oe == 0, "R8 no stretch", scl_oe, 0);
    check(irq == 1, "R5 irq on data", irq, 1);
    reg_read(2'd2, 1'b1, v); check(v == 8'h3C, "R6 data read", v, 8'h3C);
    reg_read(2'd3, 1'b0, v); check(v[0] == 0, "R6 bf clear", v[0], 0);
    reg_write(2'd3, 8'h08); wclk(1);
    check(irq == 0, "R5 irq cleared", irq, 0);
    send_byte(8'hC3, ack); check(ack, "R5 second data", ack, 1);
    send_byte(8'h5A, ack); check(!ack, "R7 overflow nack", ack, 0);
    check(scl_oe == 0, "R8 no stretch after nack", scl_oe, 0);
    reg_read(2'd3, 1'b0, v); check(v[2] == 1, "R7 ovf set", v[2], 1);
    reg_read(2'd2, 1'b1, v); check(v == 8'hC3, "R7 buffer kept", v, 8'hC3);
    send_byte(8'h77, ack); check(ack, "R7 ack after read", ack, 1);
    reg_write(2'd3, 8'h08);
    reg_read(2'd3, 1'b0, v); check(v[2] == 1, "R7 ovf sticky", v[2], 1);
    reg_write(2'd3, 8'h04);
    reg_read(2'd3, 1'b0, v); check(v[2] == 0, "R7 ovf cleared", v[2], 0);
    reg_read(2'd2, 1'b1, v); check(v == 8'h77, "R5 third data", v, 8'h77);
    bus_stop();

    // R9: byte without START after STOP
    m_scl_low = 1'b1; wclk(Q);
    send_byte(HI_CMP, ack); check(!ack, "R9 ignored after stop", ack, 0);
    reg_read(2'd3, 1'b0, v); check(v == 8'h00, "R9 no flags", v, 0);
    bus_stop();

    // R10: mismatch, then a matching pattern in the same transfer
    bus_start();
    send_byte(8'hF6, ack); check(!ack, "R10 miss nack", ack, 0);
    send_byte(HI_CMP, ack); check(!ack, "R10 later byte ignored", ack, 0);
    reg_read(2'd3, 1'b0, v); check(v == 8'h00, "R10 flags", v, 0);
    check(scl_oe == 0, "R10 no hold", scl_oe, 0);
    bus_stop();

    finish_report();
  end
endmodule